// File: doc/BRIEF.md
# Register-Driven Serial Flash Shift Engine

This block is a half-duplex SPI master that sits behind a small 32-bit register bus and talks to a serial flash. Software picks the chip-select levels directly, chooses a transfer size of one or four bytes, and then moves data by touching the data register. A write there launches an outgoing shift. A read there stalls the bus until the incoming bytes have been clocked in, and then returns them.

Single-byte transfers always use the top byte lane of the 32-bit word. For four-byte transfers, two configuration bits select the lane order independently for each direction: most-significant byte first, or least-significant byte first. Within a byte, bits always go out most-significant first. The serial clock runs in mode 0 at a fixed fraction of the system clock.

Top module: `spi_flash_shifter`

## Requirements
- R1: After reset, both chip-select pins are 1 and SCLK is 0. The control/status register (offset 0x08) reads 0xC800_0000, which means both select bits set, length 0 and ready set. The configuration register (offset 0x00) reads 0.
- R2: Control/status bit 31 drives `spi_cs0_n` and bit 30 drives `spi_cs1_n` directly, and both read back. Each pin changes only on a write to offset 0x08.
- R3: The configuration register at 0x00 holds the read byte-order bit at position 28 and the write byte-order bit at position 27, and both read back. Reading an unmapped offset returns 0 with no wait.
- R4: A write to the data register (0x0C) while ready (control/status bit 27) is 1 starts a transmit. Ready then reads 0 until the last SCLK falling edge, after which it reads 1 again.
- R5: A length field (control/status bits 29:28) of 3 gives a 4-byte transfer of 32 SCLK pulses. Every other value gives a 1-byte transfer of 8 pulses. The length is latched when a transfer starts.
- R6: A 1-byte transmit sends data bits 31:24, most-significant bit first.
- R7: A 4-byte transmit sends bytes 31:24, 23:16, 15:8, 7:0 in that order when the write order bit is 1. When the bit is 0 it sends them in the reverse order, 7:0 first. Each byte goes out MSB first.
- R8: The interface uses mode 0. SCLK idles low, MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and one SCLK period lasts `CLK_DIV` system clocks.
- R9: A read of the data register holds `bus_wait` at 1 until the bytes have been received. A 1-byte receive returns the byte in bits 31:24 with the lower bits set to 0. `bus_wait` is only ever 1 during a data-register read.
- R10: In a 4-byte receive with the read order bit set to 1, the first byte on the wire lands in bits 31:24. With the bit set to 0, the first byte lands in bits 7:0 and the fourth byte in bits 31:24.
- R11: A write to the data register while a transfer is in progress is ignored. The transfer already running sends its original data, and no extra transfer follows.
- R12: During a receive, MOSI stays at 0 (half duplex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe, held while `bus_wait` is 1 |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_rd` is 1 and `bus_wait` is 0 |
| bus_wait | output | 1 | Stalls the current read |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs0_n | output | 1 | Chip select 0, active low |
| spi_cs1_n | output | 1 | Chip select 1, active low |

## Verification
A flash model in the bench shifts a known pattern onto MISO and records every bit on MOSI at each SCLK rise. Each transfer is then compared, bit for bit, with a stream built independently from the word, the length code and the order bits. Random words are crossed with all four length codes, both byte orders and both directions, so that a swapped lane, a reversed byte, a wrong pulse count or a misplaced single-byte lane each produce a different mismatch. Directed cases add a write during a busy transfer, length codes 1 and 2, chip-select toggling, an unmapped offset, and the measured SCLK period.

// File: rtl/spi_shifter_pkg.sv
package spi_shifter_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFS_CFG  = 32'h0;
  localparam int unsigned OFS_CSR  = 32'h8;
  localparam int unsigned OFS_DATA = 32'hC;
  localparam int unsigned BIT_CS0  = 31;
  localparam int unsigned BIT_CS1  = 30;
  localparam int unsigned BIT_LENH = 29;
  localparam int unsigned BIT_RDY  = 27;
  localparam int unsigned BIT_RBIG = 28;
  localparam int unsigned BIT_WBIG = 27;

  // reverse the four byte lanes of a word
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // word as it leaves the shifter, first wire bit at [31]
  function automatic logic [DATA_W-1:0] tx_stream(input logic [DATA_W-1:0] w,
                                                  input logic quad, input logic big);
    if (!quad)    return {w[31:24], 24'h0};
    else if (big) return w;
    else          return lane_swap(w);
  endfunction

  // register word from the raw shift contents (last bit at [0])
  function automatic logic [DATA_W-1:0] rx_word(input logic [DATA_W-1:0] sr,
                                                input logic quad, input logic big);
    if (!quad)    return {sr[7:0], 24'h0};
    else if (big) return sr;
    else          return lane_swap(sr);
  endfunction

  function automatic logic [5:0] bit_total(input logic quad);
    return quad ? 6'd32 : 6'd8;
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rx,
  input  logic [5:0]        start_bits,
  input  logic [DATA_W-1:0] start_word,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              rx_mode,
  output logic              last_fall,
  output logic [DATA_W-1:0] shift_word
);
  logic [DATA_W-1:0] sr_q;
  logic [5:0]        left_q;
  logic              sclk_q, busy_q, rx_q;
  logic              rise_evt, fall_evt;

  assign rise_evt   = busy_q && tick && !sclk_q;
  assign fall_evt   = busy_q && tick && sclk_q;
  assign last_fall  = fall_evt && (left_q == 6'd1);
  assign sclk       = sclk_q;
  assign busy       = busy_q;
  assign rx_mode    = rx_q;
  assign mosi       = busy_q && !rx_q && sr_q[DATA_W-1];
  assign shift_word = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0; left_q <= '0; sclk_q <= 1'b0; busy_q <= 1'b0; rx_q <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      rx_q   <= start_rx;
      left_q <= start_bits;
      sr_q   <= start_rx ? '0 : start_word;
      sclk_q <= 1'b0;
    end else if (rise_evt) begin
      sclk_q <= 1'b1;
      if (rx_q) sr_q <= {sr_q[DATA_W-2:0], miso};
    end else if (fall_evt) begin
      sclk_q <= 1'b0;
      left_q <= left_q - 1'b1;
      if (!rx_q) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
      if (left_q == 6'd1) busy_q <= 1'b0;
    end
  end

  // R8: data only moves while the clock is low
  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));
  // R4: the last falling edge ends the shift with the clock parked low
  assert_finish_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_fall |=> (!sclk_q && !busy_q));
  // R12: no output data while collecting
  assert_rx_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rx_q) |-> !mosi);
endmodule

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter
  import spi_shifter_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_wait,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs0_n,
  output logic              spi_cs1_n
);
  localparam int unsigned HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic sel_cfg, sel_csr, sel_data;
  logic cs0_q, cs1_q, rd_big_q, wr_big_q, xfer_quad_q, xfer_big_q, rx_have_q;
  logic [1:0] len_q;
  logic [DATA_W-1:0] data_q, shift_word, start_word;
  logic busy, rx_mode, last_fall, tick, sclk, mosi;
  logic quad_now, start_tx, start_rx, start_any, ready;

  assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_csr  = (bus_addr == ADDR_W'(OFS_CSR));
  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign quad_now = (len_q == 2'b11);
  assign ready    = !busy;

  // internal events exposed for the checks
  assign start_tx  = bus_wr && sel_data && !busy;
  assign start_rx  = bus_rd && sel_data && !busy && !rx_have_q && !start_tx;
  assign start_any = start_tx || start_rx;
  assign start_word = tx_stream(bus_wdata, quad_now, wr_big_q);

  spi_half_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick));

  spi_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start_any), .start_rx(start_rx),
    .start_bits(bit_total(quad_now)), .start_word(start_word), .tick(tick),
    .miso(spi_miso), .sclk(sclk), .mosi(mosi), .busy(busy), .rx_mode(rx_mode),
    .last_fall(last_fall), .shift_word(shift_word));

  assign spi_sclk  = sclk;
  assign spi_mosi  = mosi;
  assign spi_cs0_n = cs0_q;
  assign spi_cs1_n = cs1_q;
  assign bus_wait  = bus_rd && sel_data && !rx_have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs0_q <= 1'b1; cs1_q <= 1'b1; len_q <= 2'b00;
      rd_big_q <= 1'b0; wr_big_q <= 1'b0;
      xfer_quad_q <= 1'b0; xfer_big_q <= 1'b0;
      rx_have_q <= 1'b0; data_q <= '0;
    end else begin
      if (bus_wr && sel_cfg) begin
        rd_big_q <= bus_wdata[BIT_RBIG];
        wr_big_q <= bus_wdata[BIT_WBIG];
      end
      if (bus_wr && sel_csr) begin
        cs0_q <= bus_wdata[BIT_CS0];
        cs1_q <= bus_wdata[BIT_CS1];
        len_q <= bus_wdata[BIT_LENH -: 2];
      end
      if (start_rx) begin
        xfer_quad_q <= quad_now;
        xfer_big_q  <= rd_big_q;
      end
      if (last_fall && rx_mode) begin
        data_q    <= rx_word(shift_word, xfer_quad_q, xfer_big_q);
        rx_have_q <= 1'b1;
      end else if (bus_rd && sel_data && rx_have_q) begin
        rx_have_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg) begin
      bus_rdata[BIT_RBIG] = rd_big_q;
      bus_rdata[BIT_WBIG] = wr_big_q;
    end else if (sel_csr) begin
      bus_rdata = {cs0_q, cs1_q, len_q, ready, 27'h0};
    end else if (sel_data) begin
      bus_rdata = data_q;
    end
  end

  // R9: stalls belong only to data reads
  assert_wait_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> (bus_rd && sel_data));
  // R4: a launched write drops ready on the next cycle
  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |=> !ready);
  // R2: select pins move only on a control write
  assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_csr) |=> $stable({spi_cs0_n, spi_cs1_n}));
  // R11: a write during a shift does not disturb it
  assert_busy_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_data && busy && !last_fall) |=> busy);
  // R9: a held result never coexists with an active shift
  assert_result_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_have_q |-> !busy);
endmodule

// File: tb/test_spi_flash_shifter.sv
`timescale 1ns/1ps
module test_spi_flash_shifter;
  localparam int unsigned CLK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_wait, spi_sclk, spi_mosi, spi_miso, spi_cs0_n, spi_cs1_n;

  int n_chk = 0, n_err = 0;
  int mon_cnt = 0, bad_period = 0, bad_mosi = 0;
  logic [31:0] mon_bits = '0, slave = '0;
  bit mon_rx = 1'b0;
  realtime last_rise = 0;

  always #5 clk = ~clk;

  spi_flash_shifter #(.ADDR_W(4), .CLK_DIV(CLK_DIV)) i_spi_flash_shifter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n));

  // flash model: capture on rise, present next bit after fall
  assign spi_miso = slave[31];
  always @(posedge spi_sclk) begin
    if (mon_cnt > 0 && ($realtime - last_rise) != CLK_DIV * 10.0) bad_period++;
    last_rise = $realtime;
    mon_bits = {mon_bits[30:0], spi_mosi};
    mon_cnt++;
    if (mon_rx && spi_mosi) bad_mosi++;
  end
  always @(negedge spi_sclk) slave = {slave[30:0], 1'b0};

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1;
    while (bus_wait) begin @(negedge clk); #1; end
    d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h8, s);
      if (s[27]) break;
    end
  endtask

  // wire stream, right aligned, from word / length / order
  function automatic logic [31:0] exp_wire(input logic [31:0] w, input bit quad, input bit big);
    logic [31:0] s = '0;
    int nb = quad ? 4 : 1;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b;
      if (!quad) b = w[31:24];
      else if (big) b = w[31 - 8*k -: 8];
      else b = w[8*k +: 8];
      s = (s << 8) | 32'(b);
    end
    return s;
  endfunction

  // register word from bytes seen on the wire (first at wire[31:24])
  function automatic logic [31:0] exp_recv(input logic [31:0] wire_w, input bit quad, input bit big);
    logic [31:0] r = '0;
    if (!quad) return {wire_w[31:24], 24'h0};
    for (int k = 0; k < 4; k++) begin
      if (big) r[31 - 8*k -: 8] = wire_w[31 - 8*k -: 8];
      else     r[8*k +: 8]      = wire_w[31 - 8*k -: 8];
    end
    return r;
  endfunction

  task automatic do_tx(input logic [31:0] w, input logic [1:0] len, input bit big, input string req);
    bit quad = (len == 2'b11);
    logic [31:0] s;
    wr(4'h0, {3'b0, 1'b0, big, 27'h0});
    wr(4'h8, {2'b01, len, 28'h0});
    mon_cnt = 0; mon_bits = '0; mon_rx = 1'b0; bad_period = 0;
    wr(4'hC, w);
    rd(4'h8, s);
    chk({req, " R4 ready low"}, 32'(s[27]), 32'd0);
    wait_ready();
    chk({req, " R5 pulses"}, 32'(mon_cnt), quad ? 32'd32 : 32'd8);
    chk({req, " R6/R7 stream"}, mon_bits, exp_wire(w, quad, big));
    chk({req, " R8 period"}, 32'(bad_period), 32'd0);
  endtask

  task automatic do_rx(input logic [31:0] wire_w, input logic [1:0] len, input bit big, input string req);
    bit quad = (len == 2'b11);
    logic [31:0] d, s;
    wr(4'h0, {3'b0, big, 1'b0, 27'h0});
    wr(4'h8, {2'b01, len, 28'h0});
    wait_ready();
    mon_cnt = 0; mon_bits = '0; mon_rx = 1'b1; bad_mosi = 0; slave = wire_w;
    rd(4'hC, d);
    mon_rx = 1'b0;
    chk({req, " R9/R10 word"}, d, exp_recv(wire_w, quad, big));
    chk({req, " R5 pulses"}, 32'(mon_cnt), quad ? 32'd32 : 32'd8);
    chk({req, " R12 mosi low"}, 32'(bad_mosi), 32'd0);
    rd(4'h8, s);
    chk({req, " R4 ready after read"}, 32'(s[27]), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 sclk", 32'(spi_sclk), 32'd0);
    chk("R1 cs pins", {30'h0, spi_cs0_n, spi_cs1_n}, 32'd3);
    rd(4'h8, d); chk("R1 csr", d, 32'hC800_0000);
    rd(4'h0, d); chk("R1 cfg", d, 32'h0);
    // R2 chip selects
    wr(4'h8, 32'h4000_0000);
    chk("R2 cs0 low", 32'(spi_cs0_n), 32'd0);
    chk("R2 cs1 high", 32'(spi_cs1_n), 32'd1);
    rd(4'h8, d); chk("R2 readback", d, 32'h4800_0000);
    wr(4'h8, 32'h8000_0000);
    chk("R2 swap", {30'h0, spi_cs0_n, spi_cs1_n}, 32'd2);
    // R3 map
    wr(4'h0, 32'h1800_0000);
    rd(4'h0, d); chk("R3 cfg readback", d, 32'h1800_0000);
    rd(4'h4, d); chk("R3 unmapped", d, 32'h0);
    // directed transmit corners
    do_tx(32'hA5C3_0F81, 2'b00, 1'b0, "R6 single");
    do_tx(32'h1234_5678, 2'b11, 1'b1, "R7 quad big");
    do_tx(32'h1234_5678, 2'b11, 1'b0, "R7 quad little");
    do_tx(32'h8100_00FF, 2'b01, 1'b1, "R5 len1");
    do_tx(32'h7E00_0000, 2'b10, 1'b0, "R5 len2");
    chk("R8 idle sclk", 32'(spi_sclk), 32'd0);
    // R11 write while busy
    wr(4'h8, 32'h4000_0000);
    mon_cnt = 0; mon_bits = '0;
    wr(4'hC, 32'h3C00_0000);
    wr(4'hC, 32'hFF00_0000);
    wait_ready();
    repeat (4 * CLK_DIV) @(negedge clk);
    chk("R11 original data", mon_bits, 32'h3C);
    chk("R11 no extra", 32'(mon_cnt), 32'd8);
    // directed receive corners
    do_rx(32'hDEAD_BEEF, 2'b00, 1'b0, "R9 single");
    do_rx(32'h0102_0304, 2'b11, 1'b1, "R10 quad big");
    do_rx(32'h0102_0304, 2'b11, 1'b0, "R10 quad little");
    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [31:0] w = $urandom;
      logic [1:0] len = 2'($urandom);
      bit big = 1'($urandom);
      if ($urandom % 2) do_tx(w, len, big, "rand tx");
      else              do_rx(w, len, big, "rand rx");
    end
    summary();
    $finish;
  end
endmodule